// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a write-only serial slave. A host shifts configuration bytes into a bank of eleven 8-bit registers, and the block turns the fields of two of those registers into control signals for a converter datapath. The serial link uses three wires: an active-low select, a serial clock and a data line. The serial clock and select are oversampled in the system clock domain, so the serial clock may run at no more than half the system clock rate. In practice each of its phases must last at least one system clock.

A write is a 16-bit frame, sent most significant bit first while select is low. The frame starts with a three-bit tag that must be `100`. A five-bit register index follows, then eight data bits. A frame that is cut short, carries a wrong tag or names an index past the bank causes no write. Bits that arrive after the sixteenth in the same select window are ignored.

While reset is high, the bank loads its fixed defaults. Two default bits come from strap latches. These latches sample the select and serial clock pin levels while reset and the strap-enable input are both high. Outside reset the strap latches keep their values.

Top module: `cfg_spi_regbank`

## Requirements
- R1: While reset is high the registers take the values 0x48, 0x8F, 0xF0, 0x00, 0x00, 0x82, 0x00, 0x00 at indices 0 to 7 and 0x00 at index 10. Register byte i appears on `cfg_flat[8i+7:8i]`.
- R2: If the strap latches saw select low during reset, bit 0 of index 8 resets to 1; if they saw it high, it resets to 0. Bit 0 of index 9 resets to 1 after a low serial clock strap and to 0 after a high one. The other bits of index 9 reset to 0x24, and the other bits of index 8 reset to 0.
- R3: A 16-bit frame with tag `100` in bits 15:13, index in bits 12:8 and data in bits 7:0 stores the data byte in the register at that index. Indices 0 through 10 are valid, and every bit of the byte is stored.
- R4: A frame whose tag is not `100` writes no register.
- R5: A frame whose index is above 10 writes no register.
- R6: If select rises before the sixteenth serial clock rising edge, no register is written. The next frame is then decoded from its own first bit.
- R7: Serial clock edges after the sixteenth in one select-low window have no effect.
- R8: The written value appears on `cfg_flat` on the fourth rising system clock edge after the serial clock rise that carries bit 16. It does not appear on an earlier edge.
- R9: `conv_off` equals bit 3 of register index 8.
- R10: `div_log2` decodes bits 1:0 of index 8: 00 gives 0 (divide by 1), 01 gives 1 (divide by 2), 11 gives 2 (divide by 4), and the reserved code 10 gives 0.
- R11: From register index 9: `slot_second` is bit 6, `bus_master` is bit 4, and `short_sync` is bit 0 (1 = short frame sync, 0 = long).
- R12: `strap_en` has no effect while reset is low. A later reset without `strap_en` restores the strap values captured earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Capture strap levels during reset |
| spi_ss_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock, sampled on its rising edge |
| spi_mosi | input | 1 | Serial data, most significant bit first |
| cfg_flat | output | 88 | All eleven registers, index i at bits 8i+7:8i |
| conv_off | output | 1 | Converter path disable |
| div_log2 | output | 2 | Clock divider exponent |
| slot_second | output | 1 | Receive in the second channel slot |
| bus_master | output | 1 | Audio port master mode |
| short_sync | output | 1 | Short frame sync protocol |

## Verification
The whole bank is visible on `cfg_flat`, so a corrupted bit counter or a misdecoded frame appears there. It shows up either as a byte landing at the wrong index or as a change after a frame that should have been dropped. It becomes visible four system clocks after the sixteenth serial clock rise. A stuck or misaligned shift register shows a wrong data byte in that same cycle. A strap latch that samples outside reset remains hidden until the next reset, when bit 0 of index 8 or index 9 takes the wrong value.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int NREG       = 11;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int PREFIX_W   = 3;
    localparam int FRAME_BITS = PREFIX_W + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int FLAT_W     = NREG * DATA_W;

    localparam logic [PREFIX_W-1:0] CMD_TAG = 3'b100;

    localparam int IDX_CTRL       = 8;
    localparam int IDX_AIF        = 9;
    localparam int CTRL_OFF_BIT   = 3;
    localparam int CTRL_DIV_LSB   = 0;
    localparam int AIF_SLOT_BIT   = 6;
    localparam int AIF_MASTER_BIT = 4;
    localparam int AIF_SHORT_BIT  = 0;

    typedef logic [DATA_W-1:0] cfg_byte_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        cfg_byte_t         data;
    } wr_req_t;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_DONE  = 2'd2
    } frame_st_t;

    typedef enum logic [1:0] {
        DIV_BY1 = 2'd0,
        DIV_BY2 = 2'd1,
        DIV_BY4 = 2'd2
    } div_log2_t;

    function automatic cfg_byte_t reg_default(input int idx, input logic ss_lvl,
                                              input logic sck_lvl);
        cfg_byte_t v;
        case (idx)
            0:       v = 8'h48;
            1:       v = 8'h8F;
            2:       v = 8'hF0;
            5:       v = 8'h82;
            8:       v = {7'b000_0000, ~ss_lvl};
            9:       v = {7'b001_0010, ~sck_lvl};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic frame_ok(input logic [FRAME_BITS-1:0] w);
        logic tag_ok;
        logic idx_ok;
        tag_ok = (w[FRAME_BITS-1 -: PREFIX_W] == CMD_TAG);
        idx_ok = (int'(w[DATA_W +: ADDR_W]) < NREG);
        return tag_ok && idx_ok;
    endfunction

    function automatic div_log2_t div_decode(input logic [1:0] code);
        div_log2_t d;
        case (code)
            2'b01:   d = DIV_BY2;
            2'b11:   d = DIV_BY4;
            default: d = DIV_BY1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cfgbank_sync.sv
module cfgbank_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) chain[g] <= chain[g-1];
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgbank_shifter.sv
module cfgbank_shifter
    import cfgbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ss_s,
    input  logic             sck_s,
    input  logic             mosi_s,
    output wr_req_t          wr_q,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    frame_st_t                   state;
    logic                        sck_q;
    logic [FRAME_BITS-2:0]       sh;
    logic                        sck_rise;
    logic [FRAME_BITS-1:0]       word;

    assign sck_rise = sck_s & ~sck_q;
    assign word     = {sh, mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_IDLE;
            sck_q   <= 1'b0;
            sh      <= '0;
            bit_cnt <= '0;
            wr_q    <= '0;
        end else begin
            sck_q    <= sck_s;
            wr_q.vld <= 1'b0;
            if (ss_s) begin
                state   <= FR_IDLE;
                bit_cnt <= '0;
            end else begin
                case (state)
                    FR_IDLE: begin
                        state   <= FR_SHIFT;
                        bit_cnt <= '0;
                    end
                    FR_SHIFT: begin
                        if (sck_rise) begin
                            sh      <= word[FRAME_BITS-2:0];
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                state     <= FR_DONE;
                                wr_q.vld  <= frame_ok(word);
                                wr_q.addr <= word[DATA_W +: ADDR_W];
                                wr_q.data <= word[DATA_W-1:0];
                            end
                        end
                    end
                    default: state <= FR_DONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_ss,
    input  logic              strap_sck,
    input  wr_req_t           wr,
    output logic [FLAT_W-1:0] flat
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            cfg_byte_t r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= reg_default(g, strap_ss, strap_sck);
                else if (wr.vld && (wr.addr == ADDR_W'(g)))
                    r <= wr.data;
            end
            assign flat[g*DATA_W +: DATA_W] = r;
        end
    endgenerate
endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_en,
    input  logic              spi_ss_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic [FLAT_W-1:0] cfg_flat,
    output logic              conv_off,
    output logic [1:0]        div_log2,
    output logic              slot_second,
    output logic              bus_master,
    output logic              short_sync
);
    logic [2:0]       pins_s;
    logic             ss_s;
    logic             sck_s;
    logic             mosi_s;
    logic             strap_ss;
    logic             strap_sck;
    wr_req_t          wr_q;
    logic [CNT_W-1:0] bit_cnt;
    cfg_byte_t        ctrl_b;
    cfg_byte_t        aif_b;

    cfgbank_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk (clk),
        .d   ({spi_ss_n, spi_sck, spi_mosi}),
        .q   (pins_s)
    );
    assign {ss_s, sck_s, mosi_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst && strap_en) begin
            strap_ss  <= ss_s;
            strap_sck <= sck_s;
        end
    end

    cfgbank_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .ss_s    (ss_s),
        .sck_s   (sck_s),
        .mosi_s  (mosi_s),
        .wr_q    (wr_q),
        .bit_cnt (bit_cnt)
    );

    cfgbank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .strap_ss  (strap_ss),
        .strap_sck (strap_sck),
        .wr        (wr_q),
        .flat      (cfg_flat)
    );

    assign ctrl_b      = cfg_flat[IDX_CTRL*DATA_W +: DATA_W];
    assign aif_b       = cfg_flat[IDX_AIF*DATA_W +: DATA_W];
    assign conv_off    = ctrl_b[CTRL_OFF_BIT];
    assign div_log2    = div_decode(ctrl_b[CTRL_DIV_LSB +: 2]);
    assign slot_second = aif_b[AIF_SLOT_BIT];
    assign bus_master  = aif_b[AIF_MASTER_BIT];
    assign short_sync  = aif_b[AIF_SHORT_BIT];
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ss_sync,
    input logic              wr_vld,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [FLAT_W-1:0] cfg_flat
);
    logic              last_vld;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic [DATA_W-1:0] landed;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_vld  <= 1'b0;
            last_addr <= '0;
            last_data <= '0;
        end else begin
            last_vld  <= wr_vld;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    always_comb begin
        landed = '0;
        for (int i = 0; i < NREG; i++)
            if (int'(last_addr) == i) landed = cfg_flat[i*DATA_W +: DATA_W];
    end

    p_reset_default_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_flat[7:0] == 8'h48) && (cfg_flat[15:8] == 8'h8F) &&
                       (cfg_flat[23:16] == 8'hF0) && (cfg_flat[47:40] == 8'h82) &&
                       (cfg_flat[87:80] == 8'h00))
        else $error("reset default mismatch");

    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        last_vld |-> (landed == last_data))
        else $error("write did not land");

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        wr_vld |=> !wr_vld)
        else $error("write strobe repeated");

    p_addr_legal_r5: assert property (@(posedge clk) disable iff (rst)
        wr_vld |-> (int'(wr_addr) < NREG))
        else $error("write to missing index");

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
        $past(ss_sync) |=> $stable(cfg_flat))
        else $error("bank changed with select high");

    p_bitcnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS))
        else $error("bit counter past frame");
endmodule

bind cfg_spi_regbank cfgbank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ss_sync  (ss_s),
    .wr_vld   (wr_q.vld),
    .wr_addr  (wr_q.addr),
    .wr_data  (wr_q.data),
    .bit_cnt  (bit_cnt),
    .cfg_flat (cfg_flat)
);

// File: tb/cfg_spi_regbank_tb.sv
module cfg_spi_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        strap_en;
    logic        ss_n;
    logic        sck;
    logic        mosi;
    logic [87:0] flat;
    logic        conv_off;
    logic [1:0]  div_log2;
    logic        slot_second;
    logic        bus_master;
    logic        short_sync;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_spi_regbank u_dut (
        .clk         (clk),
        .rst         (rst),
        .strap_en    (strap_en),
        .spi_ss_n    (ss_n),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .cfg_flat    (flat),
        .conv_off    (conv_off),
        .div_log2    (div_log2),
        .slot_second (slot_second),
        .bus_master  (bus_master),
        .short_sync  (short_sync)
    );

    function automatic logic [7:0] rb(input int idx);
        return flat[idx*8 +: 8];
    endfunction

    function automatic logic [15:0] frame(input logic [2:0] tag, input logic [4:0] idx,
                                          input logic [7:0] data);
        return {tag, idx, data};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ss_lvl, input logic sck_lvl, input logic use_strap);
        rst = 1'b1; ss_n = ss_lvl; sck = sck_lvl; mosi = 1'b0;
        clks(4);
        strap_en = use_strap;
        clks(4);
        strap_en = 1'b0;
        clks(2);
        ss_n = 1'b1; sck = 1'b0;
        clks(3);
        rst = 1'b0;
        clks(2);
    endtask

    task automatic xfer(input logic [31:0] pat, input int nbits);
        ss_n = 1'b0;
        clks(HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            mosi = pat[nbits-1-i];
            clks(HALF_SCK);
            sck = 1'b1;
            clks(HALF_SCK);
            sck = 1'b0;
        end
        clks(HALF_SCK);
        ss_n = 1'b1;
        clks(6);
    endtask

    task automatic wr(input int idx, input logic [7:0] data);
        xfer({16'h0, frame(3'b100, 5'(idx), data)}, 16);
    endtask

    task automatic t_defaults_high();
        do_reset(1'b1, 1'b1, 1'b1);
        chk("R1 idx0", rb(0), 8'h48);
        chk("R1 idx1", rb(1), 8'h8F);
        chk("R1 idx2", rb(2), 8'hF0);
        chk("R1 idx3-4", {rb(3), rb(4)}, 16'h0000);
        chk("R1 idx5", rb(5), 8'h82);
        chk("R1 idx6-7", {rb(6), rb(7)}, 16'h0000);
        chk("R1 idx10", rb(10), 8'h00);
        chk("R2 idx8 ss high", rb(8), 8'h00);
        chk("R2 idx9 sck high", rb(9), 8'h24);
        chk("R9 off after reset", conv_off, 1'b0);
        chk("R11 long sync", short_sync, 1'b0);
    endtask

    task automatic t_defaults_low();
        do_reset(1'b0, 1'b0, 1'b1);
        chk("R2 idx8 ss low", rb(8), 8'h01);
        chk("R2 idx9 sck low", rb(9), 8'h25);
        chk("R10 div by 2", div_log2, 2'd1);
        chk("R11 short sync", short_sync, 1'b1);
    endtask

    task automatic t_write_basic();
        wr(3, 8'hA5);
        chk("R3 idx3", rb(3), 8'hA5);
        wr(0, 8'h3C);
        chk("R3 idx0", rb(0), 8'h3C);
        wr(10, 8'hC3);
        chk("R3 idx10", rb(10), 8'hC3);
        chk("R3 idx1 untouched", rb(1), 8'h8F);
    endtask

    task automatic t_ctrl();
        wr(8, 8'h0B);
        chk("R9 off set", conv_off, 1'b1);
        chk("R10 div by 4", div_log2, 2'd2);
        wr(8, 8'h02);
        chk("R9 off clear", conv_off, 1'b0);
        chk("R10 reserved code", div_log2, 2'd0);
        wr(8, 8'h01);
        chk("R10 div by 2 written", div_log2, 2'd1);
        wr(8, 8'h00);
        chk("R10 div by 1", div_log2, 2'd0);
    endtask

    task automatic t_aif();
        wr(9, 8'h51);
        chk("R11 fields set", {slot_second, bus_master, short_sync}, 3'b111);
        wr(9, 8'h40);
        chk("R11 slot only", {slot_second, bus_master, short_sync}, 3'b100);
        wr(9, 8'h00);
        chk("R11 fields clear", {slot_second, bus_master, short_sync}, 3'b000);
    endtask

    task automatic t_bad_tag();
        logic [87:0] snap;
        snap = flat;
        xfer({16'h0, frame(3'b101, 5'd3, 8'h11)}, 16);
        chk("R4 tag 101", flat, snap);
        xfer({16'h0, frame(3'b000, 5'd2, 8'h22)}, 16);
        chk("R4 tag 000", flat, snap);
        xfer({16'h0, frame(3'b110, 5'd4, 8'h33)}, 16);
        chk("R4 tag 110", flat, snap);
    endtask

    task automatic t_bad_addr();
        logic [87:0] snap;
        snap = flat;
        xfer({16'h0, frame(3'b100, 5'd11, 8'h77)}, 16);
        chk("R5 idx 11", flat, snap);
        xfer({16'h0, frame(3'b100, 5'd31, 8'h66)}, 16);
        chk("R5 idx 31", flat, snap);
    endtask

    task automatic t_short();
        logic [87:0] snap;
        snap = flat;
        xfer({22'h0, frame(3'b100, 5'd4, 8'h9E) >> 6}, 10);
        chk("R6 ten bits", flat, snap);
        xfer({17'h0, frame(3'b100, 5'd4, 8'h9E) >> 1}, 15);
        chk("R6 fifteen bits", flat, snap);
        wr(4, 8'h9E);
        chk("R6 next frame aligned", rb(4), 8'h9E);
    endtask

    task automatic t_long();
        logic [87:0] snap;
        wr(2, 8'h00);
        snap = flat;
        snap[23:16] = 8'h5A;
        xfer({12'h0, frame(3'b100, 5'd2, 8'h5A), 4'hF}, 20);
        chk("R7 extra bits", flat, snap);
    endtask

    task automatic t_latency();
        logic [15:0] f;
        f = frame(3'b100, 5'd6, 8'hB7);
        ss_n = 1'b0;
        clks(HALF_SCK);
        for (int i = 0; i < 15; i++) begin
            mosi = f[15-i];
            clks(HALF_SCK);
            sck = 1'b1;
            clks(HALF_SCK);
            sck = 1'b0;
        end
        mosi = f[0];
        clks(HALF_SCK);
        sck = 1'b1;
        clks(3);
        chk("R8 not yet after 3 edges", rb(6), 8'h00);
        clks(1);
        chk("R8 visible after 4 edges", rb(6), 8'hB7);
        clks(1);
        sck = 1'b0;
        clks(HALF_SCK);
        ss_n = 1'b1;
        clks(6);
    endtask

    task automatic t_strap_ignored();
        ss_n = 1'b1; sck = 1'b1;
        clks(3);
        strap_en = 1'b1;
        clks(4);
        strap_en = 1'b0;
        sck = 1'b0;
        clks(3);
        chk("R12 no change outside reset", {rb(8), rb(9)}, 16'h0125);
        do_reset(1'b1, 1'b1, 1'b0);
        chk("R12 idx8 keeps low strap", rb(8), 8'h01);
        chk("R12 idx9 keeps low strap", rb(9), 8'h25);
    endtask

    initial begin
        rst = 1'b1; strap_en = 1'b0; ss_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        t_defaults_high();
        t_write_basic();
        t_ctrl();
        t_aif();
        t_bad_tag();
        t_bad_addr();
        t_short();
        t_long();
        t_latency();
        t_defaults_low();
        t_strap_ignored();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule